// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This unit turns a system clock into CAN bit timing and recovers bits from the receive line of the bus. A programmable divider produces a time-quantum tick. A segment state machine advances only on that tick. It walks each bit through a one-quantum synchronisation segment, a first timing segment (propagation plus first phase segment) and a second timing segment (second phase segment). The bus level is captured at the boundary between the two timing segments.

A frame-level controller asserts a hard-sync request around the start-of-frame bit. A falling edge (recessive 1 to dominant 0) then restarts the bit, so that the edge lies in the synchronisation segment. Every other falling edge is a resynchronisation edge. The unit measures how far the edge sits from the synchronisation segment and lengthens the first timing segment or shortens the second, by no more than the jump width. The correction applies to the current bit only. The outputs are the sampled bit, a one-clock sample strobe, and a one-clock strobe that marks the end of each synchronisation segment.

Top module: `can_bit_timer`

## Requirements
- R1: A quantum lasts `brp_m1`+1 clock cycles. With no falling edges after the first, consecutive sample strobes are (1 + `ts1_len` + `ts2_len`) quanta apart.
- R2: After reset, `rx_bit` is 1 and both strobes are low. While the unit idles, no strobe occurs until the first falling edge on `rx_in`, whether or not hard sync is requested.
- R3: `sample_strobe` is high for exactly one clock, `ts1_len` quanta after a `bit_strobe` when no edge intervenes. `rx_bit` then takes the bus level (0 dominant, 1 recessive) and holds it until the next sample strobe.
- R4: When no edge intervenes, the next `bit_strobe` follows a sample strobe by `ts2_len`+1 quanta, and never coincides with a sample strobe.
- R5: With `hard_sync_req` high, a falling edge ends the synchronisation segment at once. `bit_strobe` pulses on the tick that sees the edge, and the sample follows `ts1_len` quanta later.
- R6: A falling edge seen on the j-th quantum (j from 1) of the first timing segment lengthens that segment by min(j, `sjw_len`) quanta.
- R7: A falling edge seen in the second timing segment with d quanta left before the next synchronisation segment (the current quantum counted) does one of two things. If d ≤ `sjw_len`, that quantum becomes the synchronisation segment. Otherwise the segment shortens by `sjw_len`.
- R8: A correction changes only the bit in which the edge occurs. The following segments have their programmed lengths.
- R9: At most one resynchronisation is applied per bit. A second falling edge in the same bit has no effect.
- R10: While `tx_dominant` is high, resynchronisation edges are ignored.
- R11: A falling edge seen in the synchronisation segment causes no correction, and rising edges never alter timing.
- R12: At `brp_m1`=0, a falling edge applied to `rx_in` between rising clock edges shows its effect on the strobes three clock cycles later, after the two-stage input synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brp_m1 | input | 6 | Prescaler value minus one (0..63) |
| ts1_len | input | 5 | First timing segment length in quanta (2..16) |
| ts2_len | input | 4 | Second timing segment length in quanta (1..8) |
| sjw_len | input | 3 | Jump width in quanta (1..4, not above ts2_len) |
| hard_sync_req | input | 1 | Restart the bit on the next falling edge |
| tx_dominant | input | 1 | Local node drives dominant; suppresses resynchronisation |
| rx_in | input | 1 | Asynchronous bus receive line |
| rx_bit | output | 1 | Last sampled bus level |
| sample_strobe | output | 1 | One-clock pulse when rx_bit is updated |
| bit_strobe | output | 1 | One-clock pulse at the end of each synchronisation segment |

## Verification
Each strobe is registered and appears in the clock cycle after the quantum tick that causes it. Any edge applied to `rx_in` therefore acts on the tick at the third rising clock edge. The bench drives inputs and reads outputs on falling clock edges and timestamps each strobe. Its expectations are intervals in clock cycles between successive strobes. These intervals are computed from segment lengths, prescaler value and the quantum in which each injected edge lands, so they do not depend on where the first tick fell.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  // Segment currently occupied by the bit timing state machine
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_SYNC = 2'd1,
    SEG_TS1  = 2'd2,
    SEG_TS2  = 2'd3
  } seg_e;

endpackage

// File: rtl/cbt_reset_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module cbt_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/cbt_prescaler.sv
// Divides the system clock into time-quantum ticks of brp_m1+1 cycles.
module cbt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp_m1,
  output logic             tq_tick
);

  logic [BRP_W-1:0] div_q;
  logic [BRP_W-1:0] div_d;

  always_comb begin
    tq_tick = (div_q >= brp_m1);
    if (tq_tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + BRP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/cbt_rx_edge.sv
// Synchronises the receive line and flags falling edges once per quantum.
module cbt_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic tq_tick,
  output logic rx_sync,
  output logic fall_edge
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;
  logic                   last_d;

  // Synchroniser chain, recessive at reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], rx_in};
    end
  end

  assign rx_sync = chain_q[SYNC_STAGES-1];

  always_comb begin
    last_d    = rx_sync;
    fall_edge = tq_tick && last_q && !rx_sync;
  end

  // Level seen at the previous quantum tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b1;
    end else if (tq_tick) begin
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/cbt_bit_fsm.sv
// Segment state machine: hard sync, bounded resynchronisation, sampling.
module cbt_bit_fsm
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 5,
  parameter int TS2_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             fall_edge,
  input  logic             rx_sync,
  input  logic             hard_sync_req,
  input  logic             tx_dominant,
  input  logic [TS1_W-1:0] ts1_len,
  input  logic [TS2_W-1:0] ts2_len,
  input  logic [SJW_W-1:0] sjw_len,
  output logic             rx_bit,
  output logic             sample_strobe,
  output logic             bit_strobe,
  output seg_e             seg
);

  // Counter must hold the first timing segment plus its largest extension
  localparam int CNT_W = TS1_W + 1;

  seg_e             seg_q,  seg_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic [CNT_W-1:0] ext_q,  ext_d;
  logic [CNT_W-1:0] cut_q,  cut_d;
  logic             done_q, done_d;
  logic             rxb_q,  rxb_d;
  logic             smp_q,  smp_d;
  logic             bst_q,  bst_d;

  logic [CNT_W-1:0] ts1_x, ts2_x, sjw_x;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] ext_new, cut_new;
  logic [CNT_W-1:0] dist_early;
  logic             restart;
  logic             resync_ok;

  always_comb begin
    ts1_x      = CNT_W'(ts1_len);
    ts2_x      = CNT_W'(ts2_len);
    sjw_x      = CNT_W'(sjw_len);
    cnt_inc    = cnt_q + CNT_W'(1);
    dist_early = ts2_x - cnt_q;
    restart    = fall_edge && ((seg_q == SEG_IDLE) || hard_sync_req);
    resync_ok  = fall_edge && !hard_sync_req && !tx_dominant && !done_q;
    ext_new    = ext_q;
    cut_new    = cut_q;

    seg_d  = seg_q;
    cnt_d  = cnt_q;
    ext_d  = ext_q;
    cut_d  = cut_q;
    done_d = done_q;
    rxb_d  = rxb_q;
    smp_d  = 1'b0;
    bst_d  = 1'b0;

    if (tq_tick) begin
      if (restart) begin
        // Quantum holding the edge is taken as the synchronisation segment
        seg_d  = SEG_TS1;
        cnt_d  = '0;
        ext_d  = '0;
        cut_d  = '0;
        done_d = 1'b1;
        bst_d  = 1'b1;
      end else begin
        unique case (seg_q)
          SEG_IDLE: begin
          end
          SEG_SYNC: begin
            // An edge here is already in place: no correction
            seg_d  = SEG_TS1;
            cnt_d  = '0;
            ext_d  = '0;
            cut_d  = '0;
            done_d = 1'b0;
            bst_d  = 1'b1;
          end
          SEG_TS1: begin
            if (resync_ok) begin
              // Late edge: stretch by the phase error, capped by the jump width
              ext_new = (cnt_inc < sjw_x) ? cnt_inc : sjw_x;
              done_d  = 1'b1;
            end
            ext_d = ext_new;
            if (cnt_inc >= ts1_x + ext_new) begin
              seg_d = SEG_TS2;
              cnt_d = '0;
              smp_d = 1'b1;
              rxb_d = rx_sync;
            end else begin
              cnt_d = cnt_inc;
            end
          end
          SEG_TS2: begin
            if (resync_ok && (dist_early <= sjw_x)) begin
              // Early edge within reach: this quantum becomes the sync segment
              seg_d  = SEG_TS1;
              cnt_d  = '0;
              ext_d  = '0;
              cut_d  = '0;
              done_d = 1'b0;
              bst_d  = 1'b1;
            end else begin
              if (resync_ok) begin
                cut_new = sjw_x;
                done_d  = 1'b1;
              end
              cut_d = cut_new;
              if (cnt_inc >= ts2_x - cut_new) begin
                seg_d = SEG_SYNC;
                cnt_d = '0;
              end else begin
                cnt_d = cnt_inc;
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

  // Segment state, advanced only on quantum ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_IDLE;
      cnt_q  <= '0;
      ext_q  <= '0;
      cut_q  <= '0;
      done_q <= 1'b0;
      rxb_q  <= 1'b1;
    end else if (tq_tick) begin
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      ext_q  <= ext_d;
      cut_q  <= cut_d;
      done_q <= done_d;
      rxb_q  <= rxb_d;
    end
  end

  // Strobes, one clock wide
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      bst_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      bst_q <= bst_d;
    end
  end

  assign rx_bit        = rxb_q;
  assign sample_strobe = smp_q;
  assign bit_strobe    = bst_q;
  assign seg           = seg_q;

endmodule

// File: rtl/can_bit_timer.sv
// Top level: reset synchroniser, quantum prescaler, edge detector, segment FSM.
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int BRP_W = 6,
  parameter int TS1_W = 5,
  parameter int TS2_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp_m1,
  input  logic [TS1_W-1:0] ts1_len,
  input  logic [TS2_W-1:0] ts2_len,
  input  logic [SJW_W-1:0] sjw_len,
  input  logic             hard_sync_req,
  input  logic             tx_dominant,
  input  logic             rx_in,
  output logic             rx_bit,
  output logic             sample_strobe,
  output logic             bit_strobe
);

  logic rst_sync_n;
  logic tq_tick;
  logic rx_sync;
  logic fall_edge;
  seg_e seg;

  cbt_reset_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbt_prescaler #(.BRP_W(BRP_W)) i_presc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .brp_m1  (brp_m1),
    .tq_tick (tq_tick)
  );

  cbt_rx_edge #(.SYNC_STAGES(2)) i_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rx_in     (rx_in),
    .tq_tick   (tq_tick),
    .rx_sync   (rx_sync),
    .fall_edge (fall_edge)
  );

  cbt_bit_fsm #(
    .TS1_W (TS1_W),
    .TS2_W (TS2_W),
    .SJW_W (SJW_W)
  ) i_fsm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .tq_tick       (tq_tick),
    .fall_edge     (fall_edge),
    .rx_sync       (rx_sync),
    .hard_sync_req (hard_sync_req),
    .tx_dominant   (tx_dominant),
    .ts1_len       (ts1_len),
    .ts2_len       (ts2_len),
    .sjw_len       (sjw_len),
    .rx_bit        (rx_bit),
    .sample_strobe (sample_strobe),
    .bit_strobe    (bit_strobe),
    .seg           (seg)
  );

endmodule

// File: rtl/can_bit_timer_chk.sv
// Property checker attached to the top level.
module can_bit_timer_chk
  import can_bt_pkg::*;
#(
  parameter int BRP_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BRP_W-1:0] brp_m1,
  input logic             tq_tick,
  input seg_e             seg,
  input logic             rx_bit,
  input logic             sample_strobe,
  input logic             bit_strobe
);

  // Cycles since the last quantum tick
  logic [BRP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (tq_tick) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + BRP_W'(1);
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |-> (gap_q == brp_m1));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_IDLE) |-> (!sample_strobe && !bit_strobe && rx_bit));

  // R3
  rx_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> sample_strobe);

  // R3
  sample_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe);

  // R3
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe || bit_strobe) |-> $past(tq_tick));

  // R4
  strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> !bit_strobe);

endmodule

bind can_bit_timer can_bit_timer_chk #(.BRP_W(BRP_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .brp_m1        (brp_m1),
  .tq_tick       (tq_tick),
  .seg           (seg),
  .rx_bit        (rx_bit),
  .sample_strobe (sample_strobe),
  .bit_strobe    (bit_strobe)
);

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;

  logic       clk;
  logic       rst_n;
  logic [5:0] brp_m1;
  logic [4:0] ts1_len;
  logic [3:0] ts2_len;
  logic [2:0] sjw_len;
  logic       hard_sync_req;
  logic       tx_dominant;
  logic       rx_in;
  logic       rx_bit;
  logic       sample_strobe;
  logic       bit_strobe;

  int cyc    = 0;
  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // Columns: brp_m1, ts1, ts2, sjw, quanta*Q bit->sample, sample->bit
  localparam int NVEC = 5;
  localparam int VEC [NVEC][6] = '{
    '{0,  2,  1, 1,   2,   2},
    '{3,  5,  3, 2,  20,  16},
    '{1,  3,  2, 2,   6,   6},
    '{7, 16,  8, 4, 128,  72},
    '{63, 4,  2, 1, 256, 192}
  };

  can_bit_timer i_can_bit_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .brp_m1        (brp_m1),
    .ts1_len       (ts1_len),
    .ts2_len       (ts2_len),
    .sjw_len       (sjw_len),
    .hard_sync_req (hard_sync_req),
    .tx_dominant   (tx_dominant),
    .rx_in         (rx_in),
    .rx_bit        (rx_bit),
    .sample_strobe (sample_strobe),
    .bit_strobe    (bit_strobe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Wait for the next strobe (1: sample, 0: bit) and return its cycle
  task automatic wait_pulse(input bit want_sample, input string req, output int when);
    bit seen = 0;
    int n    = 0;
    while (!seen && n < 5000) begin
      @(negedge clk);
      n++;
      seen = want_sample ? sample_strobe : bit_strobe;
    end
    if (!seen) begin
      checks++;
      fails++;
      $display("FAIL %s: actual no strobe expected strobe within 5000 cycles", req);
    end
    when = cyc;
  endtask

  task automatic do_reset(input int b, input int t1, input int t2, input int s);
    rst_n         = 1'b0;
    brp_m1        = 6'(b);
    ts1_len       = 5'(t1);
    ts2_len       = 4'(t2);
    sjw_len       = 3'(s);
    hard_sync_req = 1'b0;
    tx_dominant   = 1'b0;
    rx_in         = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // Start from idle, send one dominant bit, go recessive; return at a bit strobe
  task automatic start_bus(output int t0);
    int t;
    @(negedge clk);
    rx_in = 1'b0;
    wait_pulse(1'b0, "R2", t);
    wait_pulse(1'b1, "R3", t);
    rx_in = 1'b1;
    wait_pulse(1'b0, "R11", t0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1, t2, t3, td, cnt;

    // Reset state and idle (R2)
    do_reset(0, 8, 4, 2);
    chk_eq("R2 rx_bit after reset", rx_bit, 1);
    chk_eq("R2 sample_strobe after reset", sample_strobe, 0);
    chk_eq("R2 bit_strobe after reset", bit_strobe, 0);
    hard_sync_req = 1'b1;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cnt += sample_strobe + bit_strobe;
    end
    hard_sync_req = 1'b0;
    chk_eq("R2 strobes while idle", cnt, 0);

    // Input latency (R12)
    rx_in = 1'b0;
    td    = cyc;
    wait_pulse(1'b0, "R12", t0);
    chk_eq("R12 edge to bit_strobe cycles", t0 - td, 3);

    // Vector table: timing under several prescaler and segment settings
    for (int i = 0; i < NVEC; i++) begin
      do_reset(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      @(negedge clk);
      rx_in = 1'b0;
      wait_pulse(1'b0, "R3", t0);
      wait_pulse(1'b1, "R3", t1);
      chk_eq("R3 bit_strobe to sample cycles", t1 - t0, VEC[i][4]);
      chk_eq("R3 sampled dominant", rx_bit, 0);
      rx_in = 1'b1;
      wait_pulse(1'b0, "R4", t2);
      chk_eq("R4 sample to bit_strobe cycles", t2 - t1, VEC[i][5]);
      wait_pulse(1'b1, "R1", t3);
      chk_eq("R1 sample period cycles", t3 - t1,
             (1 + VEC[i][1] + VEC[i][2]) * (VEC[i][0] + 1));
      chk_eq("R3 sampled recessive", rx_bit, 1);
    end

    // Rising edge in second segment leaves timing alone (R11)
    do_reset(0, 8, 4, 2);
    @(negedge clk);
    rx_in = 1'b0;
    wait_pulse(1'b0, "R11", t0);
    wait_pulse(1'b1, "R11", t1);
    rx_in = 1'b1;
    wait_pulse(1'b0, "R11", t2);
    chk_eq("R11 rising edge no effect", t2 - t1, 5);

    // Late edge, error 3, jump width 2 (R6) then next bit unchanged (R8)
    do_reset(0, 8, 4, 2);
    start_bus(t0);
    rx_in = 1'b0;
    wait_pulse(1'b1, "R6", t1);
    chk_eq("R6 late edge capped by sjw", t1 - t0, 10);
    wait_pulse(1'b0, "R8", t2);
    chk_eq("R8 second segment after late edge", t2 - t1, 5);
    wait_pulse(1'b1, "R8", t3);
    chk_eq("R8 next bit first segment", t3 - t2, 8);

    // Late edge, error 3, jump width 4 (R6)
    do_reset(0, 8, 4, 4);
    start_bus(t0);
    rx_in = 1'b0;
    wait_pulse(1'b1, "R6", t1);
    chk_eq("R6 late edge full correction", t1 - t0, 11);

    // Two falling edges in one bit (R9)
    do_reset(0, 8, 4, 4);
    start_bus(t0);
    rx_in = 1'b0;
    @(negedge clk);
    rx_in = 1'b1;
    @(negedge clk);
    rx_in = 1'b0;
    wait_pulse(1'b1, "R9", t1);
    chk_eq("R9 second edge ignored", t1 - t0, 11);

    // Own dominant transmission suppresses resync (R10)
    do_reset(0, 8, 4, 2);
    tx_dominant = 1'b1;
    start_bus(t0);
    rx_in = 1'b0;
    wait_pulse(1'b1, "R10", t1);
    chk_eq("R10 no resync while transmitting", t1 - t0, 8);
    tx_dominant = 1'b0;

    // Early edge within jump width becomes sync segment (R7), next bit normal (R8)
    do_reset(0, 8, 4, 2);
    start_bus(t0);
    wait_pulse(1'b1, "R7", t1);
    rx_in = 1'b0;
    wait_pulse(1'b0, "R7", t2);
    chk_eq("R7 early edge taken as sync", t2 - t1, 3);
    wait_pulse(1'b1, "R8", t3);
    chk_eq("R8 first segment after early edge", t3 - t2, 8);

    // Early edge beyond jump width shortens by sjw (R7)
    do_reset(0, 8, 4, 1);
    start_bus(t0);
    wait_pulse(1'b1, "R7", t1);
    rx_in = 1'b0;
    wait_pulse(1'b0, "R7", t2);
    chk_eq("R7 early edge shortened by sjw", t2 - t1, 4);

    // Edge landing in the sync segment (R11)
    do_reset(0, 8, 4, 2);
    start_bus(t0);
    wait_pulse(1'b1, "R11", t1);
    repeat (2) @(negedge clk);
    rx_in = 1'b0;
    wait_pulse(1'b0, "R11", t2);
    chk_eq("R11 sync edge bit_strobe", t2 - t1, 5);
    wait_pulse(1'b1, "R11", t3);
    chk_eq("R11 sync edge no correction", t3 - t2, 8);

    // Hard sync in the middle of a bit (R5)
    do_reset(0, 8, 4, 2);
    start_bus(t0);
    hard_sync_req = 1'b1;
    rx_in         = 1'b0;
    wait_pulse(1'b0, "R5", t1);
    hard_sync_req = 1'b0;
    chk_eq("R5 hard sync restarts bit", t1 - t0, 3);
    wait_pulse(1'b1, "R5", t2);
    chk_eq("R5 sample after hard sync", t2 - t1, 8);

    finish_run();
  end

endmodule